// File: doc/BRIEF.md
# Grouped-Output Self-Test With One Shared Signature Register

This block wraps a combinational circuit under test and runs a pseudo-random self-test on it. A linear-feedback pattern generator drives the circuit's inputs. The circuit's outputs are wider than a single signature register can absorb at once, so they are split into equal groups. Each full test pass observes one group only. An output multiplexer picks the group and a second stage picks one bit of it each cycle. That bit is folded into one shared serial-input signature register. The pattern sequence is replayed once for every group, and a small counter steps through the groups.

When no test is running, the circuit's inputs come straight from the system inputs. A start pulse launches a test. When the final group has been compacted, the accumulated signature is compared with a parameter value, and the done and pass flags report the outcome. The flags hold until the next start.

Each pattern stays on the circuit inputs for as many cycles as a group has bits. This gives the circuit a stable input while the group is fed to the register one bit at a time.

Top module: `grpsig_bist`

## Requirements
- R1: While no test is running (after reset, and after a test completes), `cut_in` equals `sys_in`. Changes on `sys_in` during a test do not reach `cut_in`.
- R2: After reset, `done` and `pass` are 0.
- R3: A `start` seen while no test is running begins a test that lasts exactly NUM_GRP*PAT_CNT*GRP_W cycles, where NUM_GRP = OUT_W/GRP_W. Group g covers `cut_out[g*GRP_W +: GRP_W]`. Groups are visited in order 0 up to NUM_GRP-1, and `done` is 1 in the cycle after the last test cycle.
- R4: Each group pass applies the same pattern sequence. The first pattern is TPG_SEED. Each next pattern is (p<<1) XOR (TPG_POLY if the msb of p is 1). Each pattern is held on `cut_in` for GRP_W cycles, and the generator is reloaded with TPG_SEED at the start of every group pass.
- R5: Within a pattern, the selected group's bits are compacted lowest index first, one bit per cycle, using s' = (s<<1) XOR (SIG_POLY if s[msb] XOR bit). The signature is cleared to zero when a test starts and is not cleared between groups.
- R6: When `done` rises, `pass` is 1 exactly when the final signature equals EXP_SIG. `pass` is never 1 while `done` is 0.
- R7: A `start` pulse while a test is running has no effect on the pattern sequence, the test length or the result.
- R8: `done` and `pass` hold their values until the next accepted `start`, which clears both in the first test cycle.
- R9: An output error confined to any single group changes the final signature, so `pass` is 0 for it. This holds for a flipped bit in the first group, a middle group and the last group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a self-test when idle |
| sys_in | input | IN_W | System inputs passed to the circuit outside test |
| cut_in | output | IN_W | Inputs driven to the circuit under test |
| cut_out | input | OUT_W | Outputs returned from the circuit under test |
| done | output | 1 | Test finished; holds until next start |
| pass | output | 1 | Final signature matched EXP_SIG (valid with done) |

## Verification
The bench builds the block with 8 inputs and 12 outputs split into three 4-bit groups, 16 patterns per pass and a 16-bit signature. Three groups do not fill the 2-bit group counter, so the counter has to stop at group 2 and cannot run on to the unused code 3. A flipped output bit can be placed in each of the three groups in turn, so the bench can show that every group actually reaches the signature register. EXP_SIG is computed at elaboration by a bench-side model of the generator, the circuit and the signature register. The bench predicts every pattern cycle by cycle and checks the exact test length, including when a start pulse arrives in the middle of a test.

// File: rtl/grpsig_pkg.sv
package grpsig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bist_st_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/grpsig_tpg.sv
module grpsig_tpg #(
    parameter int unsigned W          = 8,
    parameter logic [W-1:0] POLY      = 'h71,
    parameter logic [W-1:0] SEED      = 'hA5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] pat
);
    typedef struct packed {
        logic [W-1:0] lfsr;
    } tpg_t;

    tpg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.lfsr = SEED;
        end else if (step) begin
            r_d.lfsr = {r_q.lfsr[W-2:0], 1'b0} ^ (r_q.lfsr[W-1] ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{lfsr: SEED};
        else        r_q <= r_d;
    end

    assign pat = r_q.lfsr;

    AST_TPG_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pat == SEED)); // R4
    AST_TPG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(pat)); // R4
    AST_TPG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pat != '0); // R4

endmodule

// File: rtl/grpsig_sisr.sv
module grpsig_sisr #(
    parameter int unsigned W       = 16,
    parameter logic [W-1:0] POLY   = 'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] sig_nxt
);
    typedef struct packed {
        logic [W-1:0] sig;
    } sisr_t;

    sisr_t r_d, r_q;
    logic  fb;

    always_comb begin
        r_d = r_q;
        fb  = r_q.sig[W-1] ^ din;
        if (clr) begin
            r_d.sig = '0;
        end else if (en) begin
            r_d.sig = {r_q.sig[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sig_nxt = r_d.sig;

    AST_SIG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (r_q.sig == '0)); // R5
    AST_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(r_q.sig)); // R5

endmodule

// File: rtl/grpsig_omux.sv
module grpsig_omux #(
    parameter int unsigned OUT_W = 12,
    parameter int unsigned GRP_W = 4,
    localparam int unsigned NUM_GRP = OUT_W / GRP_W,
    localparam int unsigned GCW     = grpsig_pkg::cnt_width(NUM_GRP),
    localparam int unsigned BCW     = grpsig_pkg::cnt_width(GRP_W)
) (
    input  logic [OUT_W-1:0] vec,
    input  logic [GCW-1:0]   grp_sel,
    input  logic [BCW-1:0]   bit_sel,
    output logic             bit_o
);
    logic [GRP_W-1:0] grp_arr [NUM_GRP];
    logic [GRP_W-1:0] sel_grp;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_split
        assign grp_arr[g] = vec[g*GRP_W +: GRP_W];
    end

    always_comb begin
        sel_grp = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (grp_sel == GCW'(g)) sel_grp = grp_arr[g];
        end
        bit_o = sel_grp[bit_sel];
    end

endmodule

// File: rtl/grpsig_seq.sv
module grpsig_seq
    import grpsig_pkg::*;
#(
    parameter int unsigned NUM_GRP   = 3,
    parameter int unsigned GRP_W     = 4,
    parameter int unsigned PAT_CNT   = 16,
    parameter int unsigned SIG_W     = 16,
    parameter logic [SIG_W-1:0] EXP_SIG = '0,
    localparam int unsigned GCW = cnt_width(NUM_GRP),
    localparam int unsigned BCW = cnt_width(GRP_W),
    localparam int unsigned PCW = cnt_width(PAT_CNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SIG_W-1:0] sig_nxt,
    output logic             run,
    output logic [GCW-1:0]   grp_sel,
    output logic [BCW-1:0]   bit_sel,
    output logic             tpg_load,
    output logic             tpg_step,
    output logic             sig_clr,
    output logic             sig_en,
    output logic             done,
    output logic             pass
);
    localparam logic [GCW-1:0] GRP_LAST = GCW'(NUM_GRP - 1);
    localparam logic [BCW-1:0] BIT_LAST = BCW'(GRP_W - 1);
    localparam logic [PCW-1:0] PAT_LAST = PCW'(PAT_CNT - 1);

    typedef struct packed {
        bist_st_e       st;
        logic [GCW-1:0] grp;
        logic [PCW-1:0] pat;
        logic [BCW-1:0] bidx;
        logic           done;
        logic           pass;
    } seq_t;

    seq_t s_d, s_q;
    logic last_bit, last_pat, last_grp;

    always_comb begin
        s_d      = s_q;
        tpg_load = 1'b0;
        tpg_step = 1'b0;
        sig_clr  = 1'b0;
        sig_en   = 1'b0;
        last_bit = (s_q.bidx == BIT_LAST);
        last_pat = (s_q.pat  == PAT_LAST);
        last_grp = (s_q.grp  == GRP_LAST);
        case (s_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    s_d.st   = ST_RUN;
                    s_d.grp  = '0;
                    s_d.pat  = '0;
                    s_d.bidx = '0;
                    s_d.done = 1'b0;
                    s_d.pass = 1'b0;
                    tpg_load = 1'b1;
                    sig_clr  = 1'b1;
                end
            end
            ST_RUN: begin
                sig_en = 1'b1;
                if (last_bit) begin
                    s_d.bidx = '0;
                    tpg_step = 1'b1;
                    if (last_pat) begin
                        s_d.pat  = '0;
                        tpg_load = 1'b1;
                        if (last_grp) begin
                            s_d.st   = ST_DONE;
                            s_d.grp  = '0;
                            s_d.done = 1'b1;
                            s_d.pass = (sig_nxt == EXP_SIG);
                        end else begin
                            s_d.grp = s_q.grp + 1'b1;
                        end
                    end else begin
                        s_d.pat = s_q.pat + 1'b1;
                    end
                end else begin
                    s_d.bidx = s_q.bidx + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, grp: '0, pat: '0, bidx: '0, done: 1'b0, pass: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign run     = (s_q.st == ST_RUN);
    assign grp_sel = s_q.grp;
    assign bit_sel = s_q.bidx;
    assign done    = s_q.done;
    assign pass    = s_q.pass;

    AST_GRP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        grp_sel <= GRP_LAST); // R3
    AST_DONE_LAST_GRP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(grp_sel) == GRP_LAST && $past(run))); // R3
    AST_GRP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$stable(grp_sel)) |-> ($past(s_q.pat) == PAT_LAST && $past(bit_sel) == BIT_LAST)); // R4
    AST_RUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start && !(last_bit && last_pat && last_grp)) |=> (run && !done)); // R7

endmodule

// File: rtl/grpsig_bist.sv
module grpsig_bist #(
    parameter int unsigned IN_W          = 8,
    parameter int unsigned OUT_W         = 12,
    parameter int unsigned GRP_W         = 4,
    parameter int unsigned PAT_CNT       = 16,
    parameter int unsigned SIG_W         = 16,
    parameter logic [IN_W-1:0]  TPG_POLY = 'h71,
    parameter logic [IN_W-1:0]  TPG_SEED = 'hA5,
    parameter logic [SIG_W-1:0] SIG_POLY = 'h1021,
    parameter logic [SIG_W-1:0] EXP_SIG  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IN_W-1:0]  sys_in,
    output logic [IN_W-1:0]  cut_in,
    input  logic [OUT_W-1:0] cut_out,
    output logic             done,
    output logic             pass
);
    localparam int unsigned NUM_GRP = OUT_W / GRP_W;
    localparam int unsigned GCW     = grpsig_pkg::cnt_width(NUM_GRP);
    localparam int unsigned BCW     = grpsig_pkg::cnt_width(GRP_W);
    localparam logic [BCW-1:0] BIT_LAST = BCW'(GRP_W - 1);

    logic             run, tpg_load, tpg_step, sig_clr, sig_en, obs_bit;
    logic [GCW-1:0]   grp_sel;
    logic [BCW-1:0]   bit_sel;
    logic [IN_W-1:0]  tpg_pat;
    logic [SIG_W-1:0] sig_nxt;

    grpsig_seq #(
        .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .PAT_CNT(PAT_CNT),
        .SIG_W(SIG_W), .EXP_SIG(EXP_SIG)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .sig_nxt(sig_nxt),
        .run(run), .grp_sel(grp_sel), .bit_sel(bit_sel),
        .tpg_load(tpg_load), .tpg_step(tpg_step),
        .sig_clr(sig_clr), .sig_en(sig_en), .done(done), .pass(pass)
    );

    grpsig_tpg #(.W(IN_W), .POLY(TPG_POLY), .SEED(TPG_SEED)) u_tpg (
        .clk(clk), .rst_n(rst_n), .load(tpg_load), .step(tpg_step), .pat(tpg_pat)
    );

    grpsig_omux #(.OUT_W(OUT_W), .GRP_W(GRP_W)) u_omux (
        .vec(cut_out), .grp_sel(grp_sel), .bit_sel(bit_sel), .bit_o(obs_bit)
    );

    grpsig_sisr #(.W(SIG_W), .POLY(SIG_POLY)) u_sisr (
        .clk(clk), .rst_n(rst_n), .clr(sig_clr), .en(sig_en), .din(obs_bit), .sig_nxt(sig_nxt)
    );

    assign cut_in = run ? tpg_pat : sys_in;

    AST_PAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bit_sel != BIT_LAST) |=> $stable(cut_in)); // R4
    AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done); // R6
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass))); // R8

endmodule

// File: tb/grpsig_bist_test.sv
module grpsig_bist_test;
    localparam int unsigned IN_W = 8, OUT_W = 12, GRP_W = 4, PAT_CNT = 16, SIG_W = 16;
    localparam int unsigned NUM_GRP = OUT_W / GRP_W;
    localparam logic [IN_W-1:0]  TPG_POLY = 8'h71;
    localparam logic [IN_W-1:0]  TPG_SEED = 8'hA5;
    localparam logic [SIG_W-1:0] SIG_POLY = 16'h1021;

    function automatic logic [OUT_W-1:0] cut_fn(input logic [IN_W-1:0] x);
        return {x[7:4] & x[3:0], x ^ {x[6:0], x[7]}};
    endfunction

    function automatic logic [IN_W-1:0] tpg_nx(input logic [IN_W-1:0] p);
        return {p[IN_W-2:0], 1'b0} ^ (p[IN_W-1] ? TPG_POLY : '0);
    endfunction

    function automatic logic [SIG_W-1:0] sig_nx(input logic [SIG_W-1:0] s, input logic b);
        return {s[SIG_W-2:0], 1'b0} ^ ((s[SIG_W-1] ^ b) ? SIG_POLY : '0);
    endfunction

    function automatic logic [SIG_W-1:0] model_sig(input logic [OUT_W-1:0] fm);
        logic [SIG_W-1:0] s;
        logic [IN_W-1:0]  p;
        logic [OUT_W-1:0] o;
        s = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            p = TPG_SEED;
            for (int k = 0; k < PAT_CNT; k++) begin
                o = cut_fn(p) ^ fm;
                for (int b = 0; b < GRP_W; b++) s = sig_nx(s, o[g*GRP_W + b]);
                p = tpg_nx(p);
            end
        end
        return s;
    endfunction

    localparam logic [SIG_W-1:0] EXP_SIG = model_sig('0);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [IN_W-1:0]  sys_in = 8'h5A;
    logic [IN_W-1:0]  cut_in;
    logic [OUT_W-1:0] cut_out, fault = '0;
    logic done, pass;

    always #10 clk = ~clk;
    assign cut_out = cut_fn(cut_in) ^ fault;

    grpsig_bist #(
        .IN_W(IN_W), .OUT_W(OUT_W), .GRP_W(GRP_W), .PAT_CNT(PAT_CNT), .SIG_W(SIG_W),
        .TPG_POLY(TPG_POLY), .TPG_SEED(TPG_SEED), .SIG_POLY(SIG_POLY), .EXP_SIG(EXP_SIG)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sys_in(sys_in), .cut_in(cut_in),
        .cut_out(cut_out), .done(done), .pass(pass)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    bit mon_on = 0;
    logic [IN_W-1:0] pat_q[$];
    logic            res_q[$];
    string           tag_q[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor: samples 5 ns after each rising edge
    initial forever begin
        @(posedge clk);
        #5;
        if (mon_on) begin
            if (pat_q.size() > 0) begin
                logic [IN_W-1:0] e;
                e = pat_q.pop_front();
                chk(cut_in == e, "R4 pattern", cut_in, e);
                chk(done == 1'b0, "R3/R8 done low in test", done, 0);
            end else begin
                logic ep;
                string t;
                ep = res_q.pop_front();
                t  = tag_q.pop_front();
                chk(done == 1'b1, {t, " R3 done at end"}, done, 1);
                chk(pass == ep, {t, " R6 pass"}, pass, ep);
                chk(cut_in == sys_in, "R1 passthru after test", cut_in, sys_in);
                mon_on = 0;
            end
        end
    end

    task automatic run_test(input logic [OUT_W-1:0] fm, input string tag, input bit poke);
        logic [IN_W-1:0] p;
        @(negedge clk);
        fault = fm;
        for (int g = 0; g < NUM_GRP; g++) begin
            p = TPG_SEED;
            for (int k = 0; k < PAT_CNT; k++) begin
                for (int b = 0; b < GRP_W; b++) pat_q.push_back(p);
                p = tpg_nx(p);
            end
        end
        res_q.push_back(model_sig(fm) == EXP_SIG);
        tag_q.push_back(tag);
        start  = 1'b1;
        mon_on = 1;
        @(negedge clk);
        start  = 1'b0;
        sys_in = sys_in + 8'h1F;
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1; // R7: ignored while running
            @(negedge clk);
            start = 1'b0;
        end
        while (mon_on) @(negedge clk);
        repeat (4) @(negedge clk);
        sys_in = ~sys_in;
        #1;
        chk(done == 1'b1, "R8 done held", done, 1);
        chk(pass == (model_sig(fm) == EXP_SIG), "R8 pass held", pass, model_sig(fm) == EXP_SIG);
        chk(cut_in == sys_in, "R1 idle follows sys_in", cut_in, sys_in);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(done == 1'b0, "R2 done at reset", done, 0);
        chk(pass == 1'b0, "R2 pass at reset", pass, 0);
        chk(cut_in == sys_in, "R1 passthru in reset", cut_in, sys_in);
        rst_n = 1'b1;
        @(negedge clk);
        sys_in = 8'hC3;
        #1;
        chk(cut_in == 8'hC3, "R1 passthru idle", cut_in, 8'hC3);
        chk(done == 1'b0, "R2 done after reset", done, 0);
        run_test('0, "R5 clean", 1'b0);
        run_test(12'h002, "R9 fault grp0", 1'b0);
        run_test(12'h040, "R9 fault grp1", 1'b0);
        run_test(12'h800, "R9 fault grp2", 1'b0);
        chk(model_sig(12'h800) != EXP_SIG, "R9 model distinct", model_sig(12'h800), EXP_SIG);
        run_test('0, "R7 clean with start poke", 1'b1);
        run_test('0, "R8 rerun clears", 1'b0);
        finish_run();
    end

endmodule